// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt lines into a register of pending requests. Each line has its own trigger-mode bit. A line in level mode keeps its request bit equal to the pin as sampled on the last clock. A line in edge mode sets its request bit when the pin goes from low to high, and the bit then stays set until an acknowledge names that line. A priority resolver or a processor interface outside this block reads the request register and issues the acknowledges.

The trigger-mode register is loaded through a byte-wide write port. Only the bits in a per-instance writable mask can be set. The stored value is always visible on an output, so it can be read back. Each line also keeps a one-bit previous-level state machine with two states, `PIN_LOW` and `PIN_HIGH`. On every clock the next state is the current pin level. There are two transitions: the rise transition (`PIN_LOW` to `PIN_HIGH`) is the only event that sets an edge-mode request, and the fall transition (`PIN_HIGH` to `PIN_LOW`) changes nothing in the request register. All state updates on the rising clock edge and is visible one cycle after the inputs that cause it.

Top module: `irql_latch`

## Requirements
- R1: While reset is asserted, req_o and mode_o are all zero. Every line's previous level is taken as low, so a pin that is already high on the first clock after reset counts as a rise.
- R2: A line whose mode bit is 1 (level mode) shows on its req_o bit, one clock later, the pin value sampled on that clock.
- R3: A line whose mode bit is 0 (edge mode) sets its req_o bit one clock after the pin is sampled high with a previous level of low.
- R4: In edge mode, a request bit that is set stays set while the pin stays high or falls, as long as no acknowledge names that line.
- R5: In edge mode, a pin held high does not set the bit again after it has been cleared. Only a new low-to-high transition sets it.
- R6: An acknowledge (ack_valid high, ack_line = n) clears req_o[n] one clock later if line n is in edge mode. The other bits are not affected.
- R7: An acknowledge of a line in level mode has no effect: that bit keeps following the pin.
- R8: If a rise and an acknowledge of the same edge-mode line fall on the same clock, the bit is set after that clock.
- R9: A write (mode_wr_en high) stores mode_wr_data AND WRITABLE_MASK into the mode register, visible on mode_o one clock later. With no write, mode_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Raw interrupt lines, synchronous to clk |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | IDX_W | Line number being acknowledged |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_data | input | NUM_LINES | Mode write data; 1 = level, 0 = edge |
| req_o | output | NUM_LINES | Request register |
| mode_o | output | NUM_LINES | Trigger-mode register readback |

## Verification
The assertions assume that line_in is already synchronous to clk and that ack_line is a legal line number whenever ack_valid is high. The edge checks also depend on the checker's own copy of the previous pin level, which starts low at reset, just as the design's does. The stimulus changes every input only on the falling clock edge. It never drives an acknowledge index outside the eight lines. It sweeps all 256 pin patterns under several mode settings, so every line sees rises, falls, held levels and acknowledges in both modes.

// File: rtl/irql_pkg.sv
package irql_pkg;
    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_t;
endpackage

// File: rtl/irql_line_cell.sv
module irql_line_cell
    import irql_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic level_mode_i,
    input  logic ack_hit_i,
    output logic req_o
);
    pin_state_t state_q;
    pin_state_t state_d;
    logic       rise;

    // next previous-level state is simply the sampled pin
    always_comb begin
        state_d = pin_i ? PIN_HIGH : PIN_LOW;
        rise    = 1'b0;
        unique case (state_q)
            PIN_LOW:  rise = pin_i;
            PIN_HIGH: rise = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    // request output: level tracks pin; edge latches rise, ack clears (rise wins)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            req_o <= 1'b0;
        else if (level_mode_i) req_o <= pin_i;
        else if (rise)         req_o <= 1'b1;
        else if (ack_hit_i)    req_o <= 1'b0;
    end
endmodule

// File: rtl/irql_ack_decode.sv
module irql_ack_decode #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    output logic [NUM_LINES-1:0] ack_hit
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        assign ack_hit[g] = ack_valid && (ack_line == IDX_W'(g));
    end
endmodule

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
    parameter int NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WRITABLE_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] mode_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mode_q <= '0;
        else if (wr_en) mode_q <= wr_data & WRITABLE_MASK;
    end
endmodule

// File: rtl/irql_latch.sv
module irql_latch #(
    parameter int NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WRITABLE_MASK = NUM_LINES'(8'hDE),
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    input  logic                 mode_wr_en,
    input  logic [NUM_LINES-1:0] mode_wr_data,
    output logic [NUM_LINES-1:0] req_o,
    output logic [NUM_LINES-1:0] mode_o
);
    logic [NUM_LINES-1:0] ack_hit;

    irql_ack_decode #(.NUM_LINES(NUM_LINES)) u_dec (
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .ack_hit   (ack_hit)
    );

    irql_mode_reg #(.NUM_LINES(NUM_LINES), .WRITABLE_MASK(WRITABLE_MASK)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode_q  (mode_o)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irql_line_cell u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .pin_i        (line_in[g]),
            .level_mode_i (mode_o[g]),
            .ack_hit_i    (ack_hit[g]),
            .req_o        (req_o[g])
        );
    end
endmodule

// File: rtl/irql_latch_chk.sv
module irql_latch_chk #(
    parameter int NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WRITABLE_MASK = '1,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_in,
    input logic                 ack_valid,
    input logic [IDX_W-1:0]     ack_line,
    input logic                 mode_wr_en,
    input logic [NUM_LINES-1:0] mode_wr_data,
    input logic [NUM_LINES-1:0] req_o,
    input logic [NUM_LINES-1:0] mode_o
);
    // checker-side record of the last sampled pins (low after reset)
    logic [NUM_LINES-1:0] pin_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= line_in;
    end

    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (req_o == '0 && mode_o == '0 || $isunknown(rst_n));
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prop
        assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            mode_o[g] |=> req_o[g] == $past(line_in[g]));
        assert_edge_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_o[g] && line_in[g] && !pin_q[g]) |=> req_o[g]);
        assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_o[g] && req_o[g] && !(ack_valid && ack_line == IDX_W'(g))) |=> req_o[g]);
        assert_edge_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_o[g] && ack_valid && ack_line == IDX_W'(g) && !(line_in[g] && !pin_q[g]))
            |=> !req_o[g]);
        assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_o[g] && !req_o[g] && !(line_in[g] && !pin_q[g])) |=> !req_o[g]);
    end

    assert_mode_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> mode_o == ($past(mode_wr_data) & WRITABLE_MASK));
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_en |=> $stable(mode_o));
endmodule

bind irql_latch irql_latch_chk #(.NUM_LINES(NUM_LINES), .WRITABLE_MASK(WRITABLE_MASK)) u_chk (.*);

// File: tb/tb_irql_latch.sv
module tb_irql_latch;
    localparam int  CLK_PERIOD = 10;
    localparam int  N          = 8;
    localparam logic [N-1:0] BENCH_MASK = 8'hB7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_in = '0;
    logic         ack_valid = 1'b0;
    logic [2:0]   ack_line = '0;
    logic         mode_wr_en = 1'b0;
    logic [N-1:0] mode_wr_data = '0;
    logic [N-1:0] req_o;
    logic [N-1:0] mode_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // expected state derived from the requirements
    logic [N-1:0] exp_req = '0;
    logic [N-1:0] exp_prev = '0;
    logic [N-1:0] exp_mode = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irql_latch #(.NUM_LINES(N), .WRITABLE_MASK(BENCH_MASK)) dut (
        .clk, .rst_n, .line_in, .ack_valid, .ack_line,
        .mode_wr_en, .mode_wr_data, .req_o, .mode_o
    );

    task automatic check(input logic [N-1:0] got, input logic [N-1:0] want, input string tag);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, want);
        end
    endtask

    task automatic step(input logic [N-1:0] pins, input bit av, input logic [2:0] al,
                        input bit we, input logic [N-1:0] wd, input string tag);
        logic [N-1:0] nreq;
        @(negedge clk);
        line_in = pins; ack_valid = av; ack_line = al;
        mode_wr_en = we; mode_wr_data = wd;
        for (int i = 0; i < N; i++) begin
            if (exp_mode[i])                      nreq[i] = pins[i];
            else if (pins[i] && !exp_prev[i])     nreq[i] = 1'b1;
            else if (av && al == 3'(i))           nreq[i] = 1'b0;
            else                                  nreq[i] = exp_req[i];
        end
        exp_req  = nreq;
        exp_prev = pins;
        if (we) exp_mode = wd & BENCH_MASK;
        @(posedge clk);
        #1;
        check(req_o, exp_req, tag);
        check(mode_o, exp_mode, "R9 mode readback");
        ack_valid = 1'b0; mode_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] mode_set [4];
        mode_set[0] = 8'h00; mode_set[1] = 8'hFF; mode_set[2] = 8'h5A; mode_set[3] = 8'hA5;

        // R1: reset holds everything clear even with pins high
        line_in = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check(req_o, '0, "R1 req in reset");
        check(mode_o, '0, "R1 mode in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3: pin already high after reset is seen as a rise
        step(8'hFF, 1'b0, 3'd0, 1'b0, '0, "R1 first-clock rise");
        // R6: ack line 3 clears only bit 3; R5: held high does not re-set it
        step(8'hFF, 1'b1, 3'd3, 1'b0, '0, "R6 edge ack clears one bit");
        step(8'hFF, 1'b0, 3'd0, 1'b0, '0, "R5 held high no re-set");
        // R4: falling pins leave bits set
        step(8'h00, 1'b0, 3'd0, 1'b0, '0, "R4 fall keeps request");
        // R8: rise and ack of line 3 together
        step(8'h08, 1'b1, 3'd3, 1'b0, '0, "R8 rise beats ack");
        // R9: write all ones, masked
        step(8'h00, 1'b0, 3'd0, 1'b1, 8'hFF, "R9 masked write");
        // R7: ack on level line 0 has no effect while pin high
        step(8'h01, 1'b0, 3'd0, 1'b0, '0, "R2 level set");
        step(8'h01, 1'b1, 3'd0, 1'b0, '0, "R7 level ack ignored");

        // R9: sweep all write values
        for (int v = 0; v < 256; v++)
            step(8'h00, 1'b0, 3'd0, 1'b1, 8'(v), "R9 write sweep");

        // R2/R3/R4/R6/R7: pin pattern sweep under several modes
        for (int m = 0; m < 4; m++) begin
            step(8'h00, 1'b0, 3'd0, 1'b1, mode_set[m], "R9 mode select");
            for (int p = 0; p < 256; p++) begin
                step(8'(p), p[0], 3'(p >> 1), 1'b0, '0, "R2 R3 R4 R6 R7 sweep");
                step(8'(p ^ 8'h3C), p[1], 3'(p), 1'b0, '0, "R2 R3 R4 R6 R7 sweep");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule